// File: doc/BRIEF.md
# Event-Action PWM Waveform Generator

This block produces one pulse-width-modulated output from a 16-bit counter that runs up, down or up-down, advanced by a programmable clock prescaler. The output is not tied to a fixed compare rule. Four counter events each carry their own 2-bit action: the counter at zero, a compare match while rising, the counter at the period value, and a compare match while falling. Each action can leave the output unchanged, force it low, force it high or toggle it. This allows edge-aligned, center-aligned and toggled waveforms to be built from one datapath.

Period and compare values are written into shadow registers and reach the counter only at a period boundary, so software can update them at any time without producing a runt pulse. A mask override and a polarity inverter sit after the waveform register. A synchronous clear input restarts the counter and prescaler. Configuration arrives on a single-cycle parallel write port.

Top module: `ea_pwm_gen`

## Requirements
- R1: After reset `pwm_o` is 0, the active period is 0, and the output stays at 0 until the block is configured.
- R2: The prescaler value sits at address 1, bits [11:0]. The counter advances once every (prescaler + 1) clock cycles, so every output pulse width is a multiple of (prescaler + 1).
- R3: Mode 0 (control bits [1:0] at address 0; code 3 also acts as mode 0) counts up from 0 to the period P and then wraps to 0. With zero action high and compare-up action low, the output is high for C ticks and low for (P + 1 - C) ticks.
- R4: Mode 1 counts down from P to 0 and then reloads P. With period action high and compare-down action low, the output is high for (P - C) ticks and low for (C + 1) ticks.
- R5: Mode 2 counts 0 up to P and back down to 0, reversing at both ends. With compare-up action high and compare-down action low, the output is high for 2(P - C) ticks and low for 2C ticks.
- R6: Action codes sit at address 4: zero in [1:0], compare-up in [3:2], period in [5:4], compare-down in [7:6]. Code 0 keeps the output, 1 drives it low, 2 drives it high and 3 toggles it. In mode 0 with only the zero action set to toggle, the output is high and low for (P + 1) ticks each.
- R7: When several events fall on the same tick, only one action is applied. The period event wins over a compare event, and a compare event wins over the zero event, even when the winning action is "keep".
- R8: A period (address 2) or compare (address 3) write takes effect only at the next period boundary: the wrap in mode 0, the reload at zero in mode 1, or the zero turn in mode 2.
- R9: An active period of 0 stops the counter, and no event actions are applied while it is stopped.
- R10: Control bit 2 (mask enable) replaces the waveform with control bit 3 (mask level).
- R11: Control bit 4 inverts the final output, and this includes a masked level.
- R12: A one-cycle pulse on `cnt_clr_i` sets the counter to 0 in modes 0 and 2, or to the active period in mode 1, and restarts the prescaler. With prescaler 0 in mode 0, the zero action is applied on the clock edge after the clear edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address: 0 control, 1 prescaler, 2 period, 3 compare, 4 actions |
| wr_data_i | input | 16 | Write data |
| cnt_clr_i | input | 1 | Synchronous counter and prescaler clear |
| pwm_o | output | 1 | Waveform output after mask and polarity |

## Verification
Assertions check properties on every cycle. The counter never exceeds the active period. The prescaler steps by one between ticks. A mode-0 wrap lands on zero, and a mode-2 count turns down at the period. A clear zeroes the counter outside mode 1. Active values change only on a load strobe, and the waveform register holds on cycles without an event. Pulse widths for each mode, the arbitration among coinciding events, the deferral of shadow values by exactly one period, the clear-to-edge latency, and the mask and inversion levels are visible only at `pwm_o`. The bench's scenarios cover those.

// File: rtl/ea_pwm_pkg.sv
package ea_pwm_pkg;

  localparam logic [1:0] CM_UP   = 2'd0;
  localparam logic [1:0] CM_DOWN = 2'd1;
  localparam logic [1:0] CM_UPDN = 2'd2;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_PSC  = 3'd1;
  localparam logic [2:0] ADDR_PER  = 3'd2;
  localparam logic [2:0] ADDR_CMP  = 3'd3;
  localparam logic [2:0] ADDR_ACT  = 3'd4;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } act_e;

  // packed MSB first: zero action lands in bits [1:0]
  typedef struct packed {
    act_e cmp_dn;
    act_e period;
    act_e cmp_up;
    act_e zero;
  } act_cfg_t;

  typedef struct packed {
    logic period;
    logic cmp_up;
    logic cmp_dn;
    logic zero;
  } evt_t;

endpackage

// File: rtl/ea_pwm_regs.sv
module ea_pwm_regs
  import ea_pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 12,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              load_i,
  output logic [1:0]        mode_o,
  output logic              mask_en_o,
  output logic              mask_lvl_o,
  output logic              invert_o,
  output logic [PSC_W-1:0]  psc_o,
  output act_cfg_t          acts_o,
  output logic [CNT_W-1:0]  per_sh_o,
  output logic [CNT_W-1:0]  act_per_o,
  output logic [CNT_W-1:0]  act_cmp_o
);

  localparam int CTRL_W = 5;
  localparam int ACT_W  = $bits(act_cfg_t);

  logic [CTRL_W-1:0] ctrl_q;
  logic [PSC_W-1:0]  psc_q;
  logic [ACT_W-1:0]  act_q;
  logic [CNT_W-1:0]  per_sh_q, cmp_sh_q, act_per_q, act_cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      psc_q    <= '0;
      act_q    <= '0;
      per_sh_q <= '0;
      cmp_sh_q <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_CTRL: ctrl_q   <= wr_data_i[CTRL_W-1:0];
        ADDR_PSC:  psc_q    <= wr_data_i[PSC_W-1:0];
        ADDR_PER:  per_sh_q <= wr_data_i;
        ADDR_CMP:  cmp_sh_q <= wr_data_i;
        ADDR_ACT:  act_q    <= wr_data_i[ACT_W-1:0];
        default: ;
      endcase
    end
  end

  // active copies move only at a period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_per_q <= '0;
      act_cmp_q <= '0;
    end else if (load_i) begin
      act_per_q <= per_sh_q;
      act_cmp_q <= cmp_sh_q;
    end
  end

  assign mode_o     = ctrl_q[1:0];
  assign mask_en_o  = ctrl_q[2];
  assign mask_lvl_o = ctrl_q[3];
  assign invert_o   = ctrl_q[4];
  assign psc_o      = psc_q;
  assign acts_o     = act_cfg_t'(act_q);
  assign per_sh_o   = per_sh_q;
  assign act_per_o  = act_per_q;
  assign act_cmp_o  = act_cmp_q;

  assert_active_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(act_per_q) && $stable(act_cmp_q)));

endmodule

// File: rtl/ea_pwm_prescaler.sv
module ea_pwm_prescaler #(
  parameter int PSC_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PSC_W-1:0] psc_i,
  input  logic             clr_i,
  output logic             tick_o
);

  logic [PSC_W-1:0] div_q;

  // >= so a lowered divisor cannot strand the count above it
  assign tick_o = !clr_i && (div_q >= psc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              div_q <= '0;
    else if (clr_i || tick_o) div_q <= '0;
    else                      div_q <= div_q + 1'b1;
  end

  assert_psc_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !tick_o) |=> (div_q == $past(div_q) + 1'b1));

endmodule

// File: rtl/ea_pwm_counter.sv
module ea_pwm_counter
  import ea_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] per_next_i,
  output evt_t             evt_o,
  output logic             load_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             dir_up_q;
  logic             stopped, at_zero, at_per, at_top, cmp_hit, eff_up, step, boundary;

  assign stopped = (per_i == '0);
  assign at_zero = (cnt_q == '0);
  assign at_per  = (cnt_q == per_i);
  assign at_top  = (cnt_q >= per_i);
  assign cmp_hit = (cnt_q == cmp_i);
  assign step    = tick_i && !stopped;

  always_comb begin
    case (mode_i)
      CM_DOWN: eff_up = 1'b0;
      CM_UPDN: eff_up = at_zero ? 1'b1 : (at_top ? 1'b0 : dir_up_q);
      default: eff_up = 1'b1;
    endcase
  end

  always_comb begin
    case (mode_i)
      CM_DOWN, CM_UPDN: boundary = at_zero;
      default:          boundary = at_top;
    endcase
  end

  assign load_o = tick_i && (stopped || boundary);

  always_comb begin
    evt_o        = '0;
    evt_o.zero   = step && at_zero;
    evt_o.period = step && at_per;
    evt_o.cmp_up = step && cmp_hit && eff_up;
    evt_o.cmp_dn = step && cmp_hit && !eff_up;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      dir_up_q <= 1'b1;
    end else if (clr_i) begin
      cnt_q    <= (mode_i == CM_DOWN) ? per_i : '0;
      dir_up_q <= 1'b1;
    end else if (tick_i) begin
      if (stopped) begin
        cnt_q <= '0;
      end else begin
        case (mode_i)
          CM_DOWN: cnt_q <= at_zero ? per_next_i : cnt_q - 1'b1;
          CM_UPDN: cnt_q <= eff_up ? cnt_q + 1'b1 : cnt_q - 1'b1;
          default: cnt_q <= at_top ? '0 : cnt_q + 1'b1;
        endcase
        dir_up_q <= eff_up;
      end
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= per_i);

  assert_up_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i && !stopped && (mode_i == CM_UP) && at_top) |=> (cnt_q == '0));

  assert_updn_turn_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i && !stopped && (mode_i == CM_UPDN) && at_per && !at_zero)
      |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && (mode_i != CM_DOWN)) |=> (cnt_q == '0));

endmodule

// File: rtl/ea_pwm_wavegen.sv
module ea_pwm_wavegen
  import ea_pwm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  evt_t     evt_i,
  input  act_cfg_t acts_i,
  input  logic     mask_en_i,
  input  logic     mask_lvl_i,
  input  logic     invert_i,
  output logic     pwm_o
);

  act_e sel;
  logic wave_q, wave_d, pre_pol;

  // priority: period, then compare, then zero
  always_comb begin
    sel = ACT_KEEP;
    if (evt_i.period)      sel = acts_i.period;
    else if (evt_i.cmp_up) sel = acts_i.cmp_up;
    else if (evt_i.cmp_dn) sel = acts_i.cmp_dn;
    else if (evt_i.zero)   sel = acts_i.zero;
  end

  always_comb begin
    case (sel)
      ACT_LOW:    wave_d = 1'b0;
      ACT_HIGH:   wave_d = 1'b1;
      ACT_TOGGLE: wave_d = ~wave_q;
      default:    wave_d = wave_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wave_q <= 1'b0;
    else         wave_q <= wave_d;
  end

  assign pre_pol = mask_en_i ? mask_lvl_i : wave_q;
  assign pwm_o   = pre_pol ^ invert_i;

  assert_wave_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i == '0) |=> $stable(wave_q));

endmodule

// File: rtl/ea_pwm_gen.sv
module ea_pwm_gen
  import ea_pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 12,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              cnt_clr_i,
  output logic              pwm_o
);

  logic [1:0]       mode;
  logic             mask_en, mask_lvl, invert, tick, load;
  logic [PSC_W-1:0] psc;
  act_cfg_t         acts;
  logic [CNT_W-1:0] per_sh, act_per, act_cmp;
  evt_t             evt;

  ea_pwm_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .load_i     (load),
    .mode_o     (mode),
    .mask_en_o  (mask_en),
    .mask_lvl_o (mask_lvl),
    .invert_o   (invert),
    .psc_o      (psc),
    .acts_o     (acts),
    .per_sh_o   (per_sh),
    .act_per_o  (act_per),
    .act_cmp_o  (act_cmp)
  );

  ea_pwm_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .psc_i  (psc),
    .clr_i  (cnt_clr_i),
    .tick_o (tick)
  );

  ea_pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .clr_i      (cnt_clr_i),
    .mode_i     (mode),
    .per_i      (act_per),
    .cmp_i      (act_cmp),
    .per_next_i (per_sh),
    .evt_o      (evt),
    .load_o     (load)
  );

  ea_pwm_wavegen u_wave (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .acts_i     (acts),
    .mask_en_i  (mask_en),
    .mask_lvl_i (mask_lvl),
    .invert_i   (invert),
    .pwm_o      (pwm_o)
  );

endmodule

// File: tb/ea_pwm_gen_tb.sv
module ea_pwm_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        clr = 1'b0;
  logic        pwm;

  always #4 clk = ~clk;

  ea_pwm_gen u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .cnt_clr_i (clr),
    .pwm_o     (pwm)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  typedef struct {
    bit    lvl;
    int    len;
    string tag;
  } seg_t;
  seg_t exp_q[$];

  bit armed = 0;
  bit prev = 0;
  int run = 0;
  bit seg_ok = 0;

  // monitor: measure each constant run of pwm and compare against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (pwm === prev) run++;
      else begin
        if (seg_ok && exp_q.size() > 0) begin
          seg_t e;
          e = exp_q.pop_front();
          n_chk++;
          if (e.lvl != prev || e.len != run) begin
            n_fail++;
            $display("FAIL %s: segment level=%0d len=%0d expected level=%0d len=%0d",
                     e.tag, prev, run, e.lvl, e.len);
          end
        end
        run = 1;
        prev = pwm;
        seg_ok = armed;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(int mode, bit men, bit mlvl, bit inv);
    wr(3'd0, 16'(mode | (int'(men) << 2) | (int'(mlvl) << 3) | (int'(inv) << 4)));
  endtask

  task automatic acts(int z, int cu, int pr, int cd);
    wr(3'd4, 16'(z | (cu << 2) | (pr << 4) | (cd << 6)));
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_lvl(bit l, string tag);
    int t = 0;
    @(negedge clk);
    while (pwm !== l && t < 3000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 3000) chk({tag, " wait level"}, int'(pwm), int'(l));
  endtask

  task automatic push(bit l, int len, string tag);
    seg_t s;
    s.lvl = l; s.len = len; s.tag = tag;
    exp_q.push_back(s);
  endtask

  task automatic drain(string tag);
    int t = 0;
    while (exp_q.size() > 0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    if (exp_q.size() > 0) begin
      chk({tag, " scoreboard drain"}, exp_q.size(), 0);
      exp_q.delete();
    end
    armed = 0;
  endtask

  // start observing from the next rising edge of pwm
  task automatic arm(string tag);
    wait_lvl(0, tag);
    @(posedge clk);
    armed = 1;
  endtask

  task automatic hold_check(string tag, int n, bit exp);
    int bad = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm !== exp) bad++;
    end
    chk(tag, bad, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 reset pwm", int'(pwm), 0);
    hold_check("R1 idle", 20, 1'b0);

    // R3 up mode, zero->high, cmp_up->low
    cfg(0, 0, 0, 0); wr(3'd1, 16'd0);
    wr(3'd2, 16'd9); wr(3'd3, 16'd3); acts(2, 1, 0, 0);
    settle(40);
    arm("R3");
    push(1, 3, "R3"); push(0, 7, "R3"); push(1, 3, "R3"); push(0, 7, "R3");
    drain("R3");

    // R2 prescaler 2
    wr(3'd1, 16'd2); wr(3'd2, 16'd5); wr(3'd3, 16'd2);
    settle(60);
    arm("R2");
    push(1, 6, "R2"); push(0, 12, "R2"); push(1, 6, "R2");
    drain("R2");
    wr(3'd1, 16'd0);

    // R4 down mode, period->high, cmp_dn->low
    cfg(1, 0, 0, 0); wr(3'd2, 16'd7); wr(3'd3, 16'd2); acts(0, 0, 2, 1);
    settle(40);
    arm("R4");
    push(1, 5, "R4"); push(0, 3, "R4"); push(1, 5, "R4");
    drain("R4");

    // R5 up-down mode, cmp_up->high, cmp_dn->low
    cfg(2, 0, 0, 0); wr(3'd2, 16'd6); wr(3'd3, 16'd2); acts(0, 2, 0, 1);
    settle(40);
    arm("R5");
    push(1, 8, "R5"); push(0, 4, "R5"); push(1, 8, "R5");
    drain("R5");

    // R6 toggle on zero only
    cfg(0, 0, 0, 0); wr(3'd2, 16'd4); acts(3, 0, 0, 0);
    settle(40);
    arm("R6");
    push(1, 5, "R6"); push(0, 5, "R6"); push(1, 5, "R6");
    drain("R6");

    // R7 period beats compare (both at 4)
    wr(3'd3, 16'd4); acts(0, 1, 2, 0);
    settle(30);
    hold_check("R7 period over compare", 20, 1'b1);
    // R7 compare beats zero (both at 0)
    wr(3'd3, 16'd0); acts(2, 1, 0, 0);
    settle(30);
    hold_check("R7 compare over zero", 20, 1'b0);

    // R8 shadow compare write mid-period
    wr(3'd2, 16'd9); wr(3'd3, 16'd3); acts(2, 1, 0, 0);
    settle(40);
    push(1, 3, "R8"); push(0, 7, "R8"); push(1, 6, "R8"); push(0, 4, "R8");
    arm("R8");
    wait_lvl(1, "R8");
    wr(3'd3, 16'd6);
    drain("R8");

    // R12 counter clear during the low phase
    wr(3'd3, 16'd5);
    settle(40);
    wait_lvl(1, "R12");
    wait_lvl(0, "R12");
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R12 low right after clear", int'(pwm), 0);
    @(negedge clk);
    chk("R12 zero action after clear", int'(pwm), 1);
    begin
      int hi = 1;
      @(negedge clk);
      while (pwm === 1'b1 && hi < 100) begin
        hi++;
        @(negedge clk);
      end
      chk("R12 high after clear", hi, 5);
    end

    // R11 inversion of a running waveform
    cfg(0, 0, 0, 1); wr(3'd3, 16'd3);
    settle(40);
    arm("R11");
    push(1, 7, "R11"); push(0, 3, "R11"); push(1, 7, "R11");
    drain("R11");

    // R10 mask levels, R11 invert applied after mask
    acts(3, 0, 0, 0);
    cfg(0, 1, 1, 0); settle(2);
    hold_check("R10 mask high", 30, 1'b1);
    cfg(0, 1, 0, 0); settle(2);
    hold_check("R10 mask low", 30, 1'b0);
    cfg(0, 1, 1, 1); settle(2);
    hold_check("R11 mask inverted", 30, 1'b0);

    // R9 period zero stops the counter (toggle action would otherwise show)
    cfg(0, 0, 0, 0); wr(3'd2, 16'd4);
    settle(30);
    wr(3'd2, 16'd0);
    settle(30);
    begin
      bit v = pwm;
      hold_check("R9 stopped", 60, v);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule